// File: doc/BRIEF.md
# Transceiver Power Mode Sequencer

This block decides which parts of a line-interface front end are powered at each moment, and it times the reset window that comes before each transmit or receive burst. It has two ways to run. In pin mode, two request inputs from the modem engine step a seven-state machine. The states are standby, transmit reset, transmit, transmit quiet, receive reset, receive and receive quiet. A registered power-enable vector for the transmitter, RFI canceller, PGA, equalizer, ADC and tone detector is decoded from the state. In register mode, the state machine is held in standby and each power enable follows its own configuration bit.

When a burst starts, the block raises a transmit or receive reset strobe. The strobe lasts `8*(N+1)` clock cycles. N is either the programmable hold-length field or a fixed default of 13. At a 22.08 MHz clock this gives roughly 5.07 us. There are two separate quiet states. Because of this, the RFI canceller can stay powered to adapt after a receive burst, and stays off after a transmit burst. All pins are plain control levels. The block moves no data, so it has no valid/ready interface.

Top module: `xcvr_pwr_seq`

## Requirements
- R1: During and directly after reset the block is in standby: only `pwr_tone` is 1; every other power enable and both strobes are 0.
- R2: In pin mode in standby, `tx_req`=1 enters transmit reset on the next edge (also when `rx_req` is 1, since transmit has priority). `tx_req`=0 with `rx_req`=1 enters receive reset.
- R3: A reset state lasts exactly `8*(N+1)` cycles, with its strobe (`tx_rst` or `rx_rst`) high for all of them. When the window ends, the block moves to transmit or receive. The two strobes are never high together. N=0 gives 8 cycles and N=15 gives 128.
- R4: With `hold_fixed`=1, N is 13 (112 cycles). With `hold_fixed`=0, N is `hold_len`, sampled on the edge that enters the reset state.
- R5: If the active request drops during a reset state or an active state, the block moves to the matching quiet state on the next edge.
- R6: In a quiet state, the requests lead as follows. {tx,rx}=10 goes to transmit reset. 01 goes to receive reset. 11 goes to standby. 00 stays in the quiet state.
- R7: In pin mode, each state powers a fixed set of blocks. Standby powers tone only. Transmit reset and transmit power tx only. Receive reset powers pga, ceq and adc. Receive powers rfi, pga, ceq and adc. Transmit quiet powers nothing. Receive quiet powers rfi only.
- R8: `pwr_rfi` is 1 in receive quiet and is never 1 in transmit quiet.
- R9: With `pin_mode`=0, one edge later each power output equals its bit of `blk_en`. The bits are [0]=tx, [1]=rfi, [2]=pga, [3]=ceq, [4]=adc and [5]=tone. Both strobes are 0 and the state is forced to standby, so a later return to pin mode starts from standby.
- R10: All outputs are registered. In pin mode they change only on an edge that changes the state.
- R11: In receive reset or receive, `tx_req`=1 enters transmit reset on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (22.08 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset (power-on or external) |
| tx_req | input | 1 | Transmit burst request |
| rx_req | input | 1 | Receive burst request |
| pin_mode | input | 1 | 1: state machine driven by requests; 0: per-block register enables |
| hold_fixed | input | 1 | 1: fixed reset length N=13; 0: use hold_len |
| hold_len | input | 4 | Programmable reset length N, in 8-cycle ticks minus one |
| blk_en | input | 6 | Register-mode enables: [0]tx [1]rfi [2]pga [3]ceq [4]adc [5]tone |
| pwr_tx | output | 1 | Transmitter (DAC and line driver) power enable |
| pwr_rfi | output | 1 | RFI canceller power enable |
| pwr_pga | output | 1 | PGA power enable |
| pwr_ceq | output | 1 | Equalizer power enable |
| pwr_adc | output | 1 | ADC power enable |
| pwr_tone | output | 1 | Tone detector power enable |
| tx_rst | output | 1 | Transmit reset strobe |
| rx_rst | output | 1 | Receive reset strobe |

## Verification
A wrong state shows up on the power vector one edge after the faulty transition, because every state has its own output pattern apart from the two reset states. The reset states are told apart by their strobe. A timer that is off by even one prescaler tick shows up as a strobe that is one cycle too long or too short, at the moment the window ends. For that reason, reset windows of 8, 24, 112 and 128 cycles are measured exactly. A per-clock reference model catches any wrong priority or quiet-state exit on the first cycle it happens.

// File: rtl/xps_pkg.sv
package xps_pkg;
  localparam int NB    = 6;
  localparam int B_TX  = 0;
  localparam int B_RFI = 1;
  localparam int B_PGA = 2;
  localparam int B_CEQ = 3;
  localparam int B_ADC = 4;
  localparam int B_TONE = 5;

  typedef enum logic [2:0] {
    ST_STBY  = 3'd0,
    ST_TXRST = 3'd1,
    ST_TX    = 3'd2,
    ST_TXQ   = 3'd3,
    ST_RXRST = 3'd4,
    ST_RX    = 3'd5,
    ST_RXQ   = 3'd6
  } pstate_e;

  function automatic logic [NB-1:0] state_power(input pstate_e st);
    logic [NB-1:0] v;
    v = '0;
    case (st)
      ST_STBY:  v[B_TONE] = 1'b1;
      ST_TXRST,
      ST_TX:    v[B_TX] = 1'b1;
      ST_RXRST: begin v[B_PGA] = 1'b1; v[B_CEQ] = 1'b1; v[B_ADC] = 1'b1; end
      ST_RX:    begin v[B_RFI] = 1'b1; v[B_PGA] = 1'b1; v[B_CEQ] = 1'b1; v[B_ADC] = 1'b1; end
      ST_RXQ:   v[B_RFI] = 1'b1;
      default:  v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/xps_hold_timer.sv
module xps_hold_timer #(
  parameter int CNT_W = 4,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [PRE_W-1:0] PRE_ONE = {{(PRE_W-1){1'b0}}, 1'b1};

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      pre_q <= '0;
      cnt_q <= len;
    end else if (run) begin
      pre_q <= pre_q + PRE_ONE;
      if ((&pre_q) && (cnt_q != '0)) cnt_q <= cnt_q - CNT_ONE;
    end
  end

  assign done = run && (&pre_q) && (cnt_q == '0);

  // R3: the tick counter never wraps below zero
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q == '0 && !(&pre_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/xps_state_fsm.sv
module xps_state_fsm
  import xps_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pin_mode,
  input  logic    tx_req,
  input  logic    rx_req,
  input  logic    hold_done,
  output pstate_e state_q,
  output pstate_e state_d,
  output logic    load_timer,
  output logic    in_hold
);
  always_comb begin
    state_d = state_q;
    if (!pin_mode) begin
      state_d = ST_STBY;
    end else begin
      case (state_q)
        ST_STBY: begin
          if (tx_req)      state_d = ST_TXRST;
          else if (rx_req) state_d = ST_RXRST;
        end
        ST_TXRST: begin
          if (!tx_req)        state_d = ST_TXQ;
          else if (hold_done) state_d = ST_TX;
        end
        ST_TX: begin
          if (!tx_req) state_d = ST_TXQ;
        end
        ST_TXQ, ST_RXQ: begin
          if (tx_req && rx_req) state_d = ST_STBY;
          else if (tx_req)      state_d = ST_TXRST;
          else if (rx_req)      state_d = ST_RXRST;
        end
        ST_RXRST: begin
          if (tx_req)         state_d = ST_TXRST;
          else if (!rx_req)   state_d = ST_RXQ;
          else if (hold_done) state_d = ST_RX;
        end
        ST_RX: begin
          if (tx_req)       state_d = ST_TXRST;
          else if (!rx_req) state_d = ST_RXQ;
        end
        default: state_d = ST_STBY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_STBY;
    else        state_q <= state_d;
  end

  assign load_timer = ((state_d == ST_TXRST) && (state_q != ST_TXRST)) ||
                      ((state_d == ST_RXRST) && (state_q != ST_RXRST));
  assign in_hold    = (state_q == ST_TXRST) || (state_q == ST_RXRST);

  // R5: dropping the transmit request in transmit reset lands in transmit quiet
  p_tx_drop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode && state_q == ST_TXRST && !tx_req) |=> (state_q == ST_TXQ));
  // R6: both requests in a quiet state return to standby
  p_quiet_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode && (state_q == ST_TXQ || state_q == ST_RXQ) && tx_req && rx_req)
      |=> (state_q == ST_STBY));
  // R11: a transmit request pre-empts the receive side
  p_tx_preempt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode && (state_q == ST_RX || state_q == ST_RXRST) && tx_req)
      |=> (state_q == ST_TXRST));
endmodule

// File: rtl/xps_out_decode.sv
module xps_out_decode
  import xps_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_mode,
  input  pstate_e       state_d,
  input  logic [NB-1:0] blk_en,
  output logic [NB-1:0] pwr_q,
  output logic          tx_rst_q,
  output logic          rx_rst_q
);
  localparam logic [NB-1:0] RST_VEC = state_power(ST_STBY);

  logic [NB-1:0] pin_vec;
  assign pin_vec = state_power(state_d);

  for (genvar g = 0; g < NB; g++) begin : g_pwr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwr_q[g] <= RST_VEC[g];
      else        pwr_q[g] <= pin_mode ? pin_vec[g] : blk_en[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rst_q <= 1'b0;
      rx_rst_q <= 1'b0;
    end else begin
      tx_rst_q <= pin_mode && (state_d == ST_TXRST);
      rx_rst_q <= pin_mode && (state_d == ST_RXRST);
    end
  end
endmodule

// File: rtl/xcvr_pwr_seq.sv
module xcvr_pwr_seq
  import xps_pkg::*;
#(
  parameter int HOLD_W   = 4,
  parameter int PRE_W    = 3,
  parameter int DEF_HOLD = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_req,
  input  logic              rx_req,
  input  logic              pin_mode,
  input  logic              hold_fixed,
  input  logic [HOLD_W-1:0] hold_len,
  input  logic [NB-1:0]     blk_en,
  output logic              pwr_tx,
  output logic              pwr_rfi,
  output logic              pwr_pga,
  output logic              pwr_ceq,
  output logic              pwr_adc,
  output logic              pwr_tone,
  output logic              tx_rst,
  output logic              rx_rst
);
  localparam logic [HOLD_W-1:0] DEF_LEN = HOLD_W'(DEF_HOLD);

  pstate_e       state_q, state_d;
  logic          load_timer, in_hold, hold_done;
  logic [NB-1:0] pwr_q;
  logic [HOLD_W-1:0] len_eff;

  assign len_eff = hold_fixed ? DEF_LEN : hold_len;

  xps_hold_timer #(.CNT_W(HOLD_W), .PRE_W(PRE_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_timer),
    .run   (in_hold),
    .len   (len_eff),
    .done  (hold_done)
  );

  xps_state_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_mode   (pin_mode),
    .tx_req     (tx_req),
    .rx_req     (rx_req),
    .hold_done  (hold_done),
    .state_q    (state_q),
    .state_d    (state_d),
    .load_timer (load_timer),
    .in_hold    (in_hold)
  );

  xps_out_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_mode (pin_mode),
    .state_d  (state_d),
    .blk_en   (blk_en),
    .pwr_q    (pwr_q),
    .tx_rst_q (tx_rst),
    .rx_rst_q (rx_rst)
  );

  assign pwr_tx   = pwr_q[B_TX];
  assign pwr_rfi  = pwr_q[B_RFI];
  assign pwr_pga  = pwr_q[B_PGA];
  assign pwr_ceq  = pwr_q[B_CEQ];
  assign pwr_adc  = pwr_q[B_ADC];
  assign pwr_tone = pwr_q[B_TONE];

  // R3: transmit and receive reset strobes are exclusive
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_rst && rx_rst));
  // R8: canceller stays unpowered in transmit quiet
  p_rfi_off_txq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TXQ && $past(pin_mode)) |-> !pwr_rfi);
  // R9: register mode never produces a reset strobe
  p_regmode_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_mode |=> (!tx_rst && !rx_rst));
  // R10: with an unchanged state in pin mode the outputs hold
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pin_mode) && $past(pin_mode, 2) && $stable(state_q))
      |-> $stable({pwr_q, tx_rst, rx_rst}));
endmodule

// File: tb/xcvr_pwr_seq_tb.sv
module xcvr_pwr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_req = 1'b0, rx_req = 1'b0;
  logic pin_mode = 1'b1, hold_fixed = 1'b1;
  logic [3:0] hold_len = 4'd0;
  logic [5:0] blk_en = 6'd0;
  logic pwr_tx, pwr_rfi, pwr_pga, pwr_ceq, pwr_adc, pwr_tone, tx_rst, rx_rst;

  int n_tests = 0, n_fail = 0;
  bit done_flag = 1'b0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_pwr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .rx_req(rx_req),
    .pin_mode(pin_mode), .hold_fixed(hold_fixed), .hold_len(hold_len),
    .blk_en(blk_en), .pwr_tx(pwr_tx), .pwr_rfi(pwr_rfi), .pwr_pga(pwr_pga),
    .pwr_ceq(pwr_ceq), .pwr_adc(pwr_adc), .pwr_tone(pwr_tone),
    .tx_rst(tx_rst), .rx_rst(rx_rst)
  );

  // actual/expected bundle: {tx_rst, rx_rst, tone, adc, ceq, pga, rfi, tx}
  logic [7:0] act;
  assign act = {tx_rst, rx_rst, pwr_tone, pwr_adc, pwr_ceq, pwr_pga, pwr_rfi, pwr_tx};

  // ---------------- behavioural reference model ----------------
  localparam int M_STBY = 0, M_TXR = 1, M_TX = 2, M_TXQ = 3, M_RXR = 4, M_RX = 5, M_RXQ = 6;
  int m_st = M_STBY;
  int m_left = 0;
  logic [7:0] exp_v = 8'b0010_0000;

  function automatic int hold_cycles();
    int n;
    n = hold_fixed ? 13 : int'(hold_len);
    return 8 * (n + 1) - 1;
  endfunction

  function automatic logic [7:0] state_out(input int s);
    case (s)
      M_STBY: return 8'b0010_0000;
      M_TXR:  return 8'b1000_0001;
      M_TX:   return 8'b0000_0001;
      M_TXQ:  return 8'b0000_0000;
      M_RXR:  return 8'b0101_1100;
      M_RX:   return 8'b0001_1110;
      M_RXQ:  return 8'b0000_0010;
      default: return 8'b0000_0000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_STBY;
      exp_v = state_out(M_STBY);
    end else if (!pin_mode) begin
      m_st = M_STBY;
      exp_v = {2'b00, blk_en};
    end else begin
      case (m_st)
        M_STBY: begin
          if (tx_req) begin m_st = M_TXR; m_left = hold_cycles(); end
          else if (rx_req) begin m_st = M_RXR; m_left = hold_cycles(); end
        end
        M_TXR: begin
          if (!tx_req) m_st = M_TXQ;
          else if (m_left == 0) m_st = M_TX;
          else m_left--;
        end
        M_TX: if (!tx_req) m_st = M_TXQ;
        M_TXQ, M_RXQ: begin
          if (tx_req && rx_req) m_st = M_STBY;
          else if (tx_req) begin m_st = M_TXR; m_left = hold_cycles(); end
          else if (rx_req) begin m_st = M_RXR; m_left = hold_cycles(); end
        end
        M_RXR: begin
          if (tx_req) begin m_st = M_TXR; m_left = hold_cycles(); end
          else if (!rx_req) m_st = M_RXQ;
          else if (m_left == 0) m_st = M_RX;
          else m_left--;
        end
        M_RX: begin
          if (tx_req) begin m_st = M_TXR; m_left = hold_cycles(); end
          else if (!rx_req) m_st = M_RXQ;
        end
        default: m_st = M_STBY;
      endcase
      exp_v = state_out(m_st);
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n && !done_flag) begin
      n_tests++;
      if (act !== exp_v) begin
        n_fail++;
        $display("FAIL %s per-cycle model: actual=%b expected=%b", cur_req, act, exp_v);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] a, input logic [31:0] e);
    n_tests++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic drive(input logic t, input logic r);
    @(negedge clk);
    tx_req = t;
    rx_req = r;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts negedges with the selected strobe high, starting one cycle after the drive
  task automatic measure(input bit use_tx, output int n);
    n = 0;
    @(negedge clk);
    while ((use_tx ? tx_rst : rx_rst) && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (WD_LIMIT) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    int n;
    wait_cyc(3);
    cmp_on = 1'b1;
    chk("R1", {24'd0, act}, {24'd0, 8'b0010_0000});
    @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1", {24'd0, act}, {24'd0, 8'b0010_0000});

    // R2 R3 R4: fixed length 13 gives 112 cycles
    cur_req = "R4";
    drive(1'b1, 1'b0);
    measure(1'b1, n);
    chk("R4", n, 112);
    chk("R3", {30'd0, pwr_tx, tx_rst}, {30'd0, 2'b10});
    cur_req = "R5";
    drive(1'b0, 1'b0);
    @(negedge clk);
    chk("R8", {24'd0, act}, 0);

    // R4 field length 2 gives 24 receive-reset cycles
    cur_req = "R4";
    hold_fixed = 1'b0;
    hold_len = 4'd2;
    drive(1'b0, 1'b1);
    measure(1'b0, n);
    chk("R4", n, 24);
    chk("R7", {24'd0, act}, {24'd0, 8'b0001_1110});
    cur_req = "R8";
    drive(1'b0, 1'b0);
    @(negedge clk);
    chk("R8", {24'd0, act}, {24'd0, 8'b0000_0010});

    // R6 both in quiet -> standby; R2 priority from standby
    cur_req = "R6";
    drive(1'b1, 1'b1);
    @(negedge clk);
    chk("R6", {24'd0, act}, {24'd0, 8'b0010_0000});
    cur_req = "R2";
    @(negedge clk);
    chk("R2", {30'd0, tx_rst, rx_rst}, {30'd0, 2'b10});
    cur_req = "R5";
    drive(1'b0, 1'b0);
    @(negedge clk);
    chk("R5", {24'd0, act}, 0);

    // R6 00 stays quiet
    cur_req = "R6";
    wait_cyc(5);
    chk("R6", {24'd0, act}, 0);

    // R11 transmit pre-empts receive
    cur_req = "R11";
    drive(1'b0, 1'b1);
    wait_cyc(30);
    chk("R7", {24'd0, act}, {24'd0, 8'b0001_1110});
    drive(1'b1, 1'b1);
    @(negedge clk);
    chk("R11", {30'd0, tx_rst, rx_rst}, {30'd0, 2'b10});
    drive(1'b0, 1'b0);
    @(negedge clk);

    // R3 boundaries
    cur_req = "R3";
    hold_len = 4'd0;
    drive(1'b1, 1'b0);
    measure(1'b1, n);
    chk("R3", n, 8);
    drive(1'b0, 1'b0);
    hold_len = 4'd15;
    drive(1'b1, 1'b0);
    measure(1'b1, n);
    chk("R3", n, 128);
    drive(1'b0, 1'b0);
    @(negedge clk);

    // R9 register mode
    cur_req = "R9";
    @(negedge clk);
    pin_mode = 1'b0;
    blk_en = 6'b101010;
    @(negedge clk);
    chk("R9", {24'd0, act}, {24'd0, 8'b0010_1010});
    blk_en = 6'b010101;
    tx_req = 1'b1;
    @(negedge clk);
    chk("R9", {24'd0, act}, {24'd0, 8'b0001_0101});
    wait_cyc(3);
    chk("R9", {30'd0, tx_rst, rx_rst}, 0);
    tx_req = 1'b0;
    pin_mode = 1'b1;
    @(negedge clk);
    chk("R9", {24'd0, act}, {24'd0, 8'b0010_0000});
    cur_req = "R10";
    wait_cyc(4);
    chk("R10", {24'd0, act}, {24'd0, 8'b0010_0000});
    finish_run();
  end
endmodule